// File: doc/BRIEF.md
# Charge-Sum Trigger Word Generator

This block condenses the pulse activity of a multi-channel drift-chamber readout board into one short trigger word per fixed time window. Each channel receives a stream of digitized samples, qualified by a shared sample-valid strobe, and a hit flag from its timing discriminator. The block keeps the three most recent valid samples of every channel and adds them to form a charge measure.

The hit flag separates real pulse charge from baseline: a channel with no hit during the window reports zero, whatever its samples hold. A channel that did see a hit is graded against a lower and an upper threshold into a 2-bit class. The thresholds can be rewritten at run time through a small write port. At the end of every window the classes of all channels are packed into one word. That word is issued with a single-cycle valid pulse one clock after the window closes, which keeps the generation latency well inside one window.

Top module: `trig_word_gen`

## Requirements
- R1: While reset is asserted, and after it until the first window closes, `word_o` is all zeros and `word_valid_o` is low. Reset loads the lower threshold with `LOWER_RST` (default 64) and the upper threshold with `UPPER_RST` (default 512). These values decide the codes of the first windows.
- R2: A window is `WINDOW_CYCLES` clock cycles long (default 20, which is 100 ns at 200 MHz). The first window starts in the first cycle after reset is released. `word_valid_o` is high for exactly one cycle, in the cycle after each window's last cycle, so pulses are exactly `WINDOW_CYCLES` cycles apart.
- R3: A channel's charge is the unsigned sum of its three most recent samples, counting only cycles with `adc_valid_i` high, up to and including the window's last cycle. Samples present while `adc_valid_i` is low are ignored. Stored samples carry over between windows, and samples not yet received count as zero.
- R4: A channel counts as hit when its `hit_i` bit is high in any cycle of the window, the last cycle included. The hit memory is cleared after each window, so a hit never counts in the following window.
- R5: Code per channel: 0 means no hit. 3 means a hit with sum >= upper threshold. Otherwise, 2 means a hit with sum >= lower threshold, and 1 means a hit with sum below the lower threshold. The upper comparison has priority when the lower threshold exceeds the upper.
- R6: Channel c's code occupies bits [2c+1:2c] of `word_o`, so channel 0 is in bits [1:0] and channel 47 in bits [95:94].
- R7: `word_o` holds its value between valid pulses.
- R8: A cycle with `thr_we_i` high writes `thr_wdata_i` into the lower threshold when `thr_sel_i` is 0, or into the upper threshold when it is 1. The new value first applies to windows whose last cycle comes after the write cycle. A write during a window's last cycle does not affect that window.
- R9: Sums and thresholds are `SAMPLE_W+2` bits wide, so three full-scale samples (3 x 4095 = 12285 by default) never overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data_i | input | NUM_CH*SAMPLE_W | Samples of all channels; channel c in bits [c*SAMPLE_W +: SAMPLE_W] |
| adc_valid_i | input | 1 | The samples on `adc_data_i` are new this cycle |
| hit_i | input | NUM_CH | Discriminator hit flag per channel |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_sel_i | input | 1 | 0 selects the lower threshold, 1 the upper |
| thr_wdata_i | input | SAMPLE_W+2 | Threshold value to write |
| word_o | output | 2*NUM_CH | Packed trigger word |
| word_valid_o | output | 1 | One-cycle strobe marking a new trigger word |

## Verification
A wrong sample history or a lost hit memory does not show at once. It shows only as a wrong 2-bit field at the next valid pulse, so a fault stays hidden for up to one window and then appears in one channel's field. Window counter faults show within one window as a valid pulse in the wrong cycle. Threshold register faults show at the first window whose sum falls between the old and new value. The bench therefore includes exact-boundary sums and writes placed in a window's last cycle. It compares the whole word and the strobe against a behavioural model on every cycle, so that every such fault is seen at the first pulse where it matters.

// File: rtl/trig_word_pkg.sv
package trig_word_pkg;

  typedef enum logic [1:0] {
    CODE_NONE = 2'd0,
    CODE_LOW  = 2'd1,
    CODE_MID  = 2'd2,
    CODE_HIGH = 2'd3
  } trig_code_e;

  localparam logic THR_PICK_LOWER = 1'b0;
  localparam logic THR_PICK_UPPER = 1'b1;

  // Grade a hit channel's charge; the upper limit wins over the lower one.
  function automatic trig_code_e grade(input logic hit, input logic [31:0] charge,
                                       input logic [31:0] lo, input logic [31:0] hi);
    if (!hit)             return CODE_NONE;
    else if (charge >= hi) return CODE_HIGH;
    else if (charge >= lo) return CODE_MID;
    else                  return CODE_LOW;
  endfunction

endpackage

// File: rtl/trig_window.sv
module trig_window #(
  parameter int WINDOW_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end_o
);
  localparam int CNT_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign win_end_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (win_end_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R2: the phase counter never leaves the window range
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LAST)
    else $error("window counter out of range");

endmodule

// File: rtl/trig_thresh.sv
module trig_thresh #(
  parameter int SUM_W     = 14,
  parameter int LOWER_RST = 64,
  parameter int UPPER_RST = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [SUM_W-1:0] wdata_i,
  output logic [SUM_W-1:0] lo_o,
  output logic [SUM_W-1:0] hi_o
);
  import trig_word_pkg::*;

  logic wr_lo, wr_hi;
  assign wr_lo = we_i && (sel_i == THR_PICK_LOWER);
  assign wr_hi = we_i && (sel_i == THR_PICK_UPPER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_o <= SUM_W'(LOWER_RST);
      hi_o <= SUM_W'(UPPER_RST);
    end else begin
      if (wr_lo) lo_o <= wdata_i;
      if (wr_hi) hi_o <= wdata_i;
    end
  end

  // R8: thresholds change only through the write port
  p_thr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(lo_o) && $stable(hi_o)))
    else $error("threshold changed without a write");

endmodule

// File: rtl/trig_chan.sv
module trig_chan #(
  parameter int SAMPLE_W = 12,
  parameter int SUM_W    = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SAMPLE_W-1:0]       sample_i,
  input  logic                      sample_valid_i,
  input  logic                      hit_i,
  input  logic                      win_end_i,
  input  logic [SUM_W-1:0]          lo_thr_i,
  input  logic [SUM_W-1:0]          hi_thr_i,
  output trig_word_pkg::trig_code_e code_o
);
  import trig_word_pkg::*;

  localparam int TAPS = 3;

  function automatic logic [SUM_W-1:0] add3(input logic [SAMPLE_W-1:0] a,
                                            input logic [SAMPLE_W-1:0] b,
                                            input logic [SAMPLE_W-1:0] c);
    return SUM_W'(a) + SUM_W'(b) + SUM_W'(c);
  endfunction

  logic [SAMPLE_W-1:0] tap_q [TAPS];
  logic [SAMPLE_W-1:0] tap_d [TAPS];
  logic                hit_seen_q;
  logic                hit_eff;
  logic [SUM_W-1:0]    charge_next;

  always_comb begin
    if (sample_valid_i) begin
      tap_d[0] = sample_i;
      for (int i = 1; i < TAPS; i++) tap_d[i] = tap_q[i-1];
    end else begin
      for (int i = 0; i < TAPS; i++) tap_d[i] = tap_q[i];
    end
  end

  assign charge_next = add3(tap_d[0], tap_d[1], tap_d[2]);
  assign hit_eff     = hit_seen_q | hit_i;
  assign code_o      = grade(hit_eff, 32'(charge_next), 32'(lo_thr_i), 32'(hi_thr_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) tap_q[i] <= '0;
      hit_seen_q <= 1'b0;
    end else begin
      for (int i = 0; i < TAPS; i++) tap_q[i] <= tap_d[i];
      hit_seen_q <= win_end_i ? 1'b0 : hit_eff;
    end
  end

  // R4: hit memory never survives into the next window
  p_hit_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_i |=> !hit_seen_q)
    else $error("hit memory not cleared");

  // R3: samples without the valid strobe leave the history untouched
  p_taps_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid_i |=> ($stable(tap_q[0]) && $stable(tap_q[1]) && $stable(tap_q[2])))
    else $error("sample history moved without valid");

  // R4: a hit inside a window that is still open is remembered
  p_hit_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !win_end_i) |=> hit_seen_q)
    else $error("hit lost inside window");

endmodule

// File: rtl/trig_word_gen.sv
module trig_word_gen #(
  parameter int NUM_CH        = 48,
  parameter int SAMPLE_W      = 12,
  parameter int WINDOW_CYCLES = 20,
  parameter int LOWER_RST     = 64,
  parameter int UPPER_RST     = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH*SAMPLE_W-1:0] adc_data_i,
  input  logic                       adc_valid_i,
  input  logic [NUM_CH-1:0]          hit_i,
  input  logic                       thr_we_i,
  input  logic                       thr_sel_i,
  input  logic [SAMPLE_W+1:0]        thr_wdata_i,
  output logic [2*NUM_CH-1:0]        word_o,
  output logic                       word_valid_o
);
  import trig_word_pkg::*;

  localparam int SUM_W  = SAMPLE_W + 2;
  localparam int WORD_W = 2 * NUM_CH;

  logic             win_end;
  logic [SUM_W-1:0] lo_thr, hi_thr;
  trig_code_e       chan_code [NUM_CH];
  logic [WORD_W-1:0] word_d;

  trig_window #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_window (
    .clk(clk), .rst_n(rst_n), .win_end_o(win_end)
  );

  trig_thresh #(.SUM_W(SUM_W), .LOWER_RST(LOWER_RST), .UPPER_RST(UPPER_RST)) u_thresh (
    .clk(clk), .rst_n(rst_n), .we_i(thr_we_i), .sel_i(thr_sel_i),
    .wdata_i(thr_wdata_i), .lo_o(lo_thr), .hi_o(hi_thr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    trig_chan #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .sample_i(adc_data_i[c*SAMPLE_W +: SAMPLE_W]),
      .sample_valid_i(adc_valid_i),
      .hit_i(hit_i[c]),
      .win_end_i(win_end),
      .lo_thr_i(lo_thr), .hi_thr_i(hi_thr),
      .code_o(chan_code[c])
    );
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) word_d[2*c +: 2] = chan_code[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= win_end;
      if (win_end) word_o <= word_d;
    end
  end

  // R2: the strobe is one cycle wide
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o)
    else $error("valid wider than one cycle");

  // R2: each window close is followed by a strobe
  p_valid_after_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> word_valid_o)
    else $error("window closed without strobe");

  // R7: the word only moves when a window closes
  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(word_o))
    else $error("word changed between windows");

endmodule

// File: tb/tb_trig_word_gen.sv
module tb_trig_word_gen;
  localparam int NCH = 48;
  localparam int SW  = 12;
  localparam int WIN = 20;
  localparam int LO_RST = 64;
  localparam int HI_RST = 512;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rst_n;
  logic [NCH*SW-1:0]   adc_data;
  logic                adc_valid;
  logic [NCH-1:0]      hit;
  logic                thr_we, thr_sel;
  logic [SW+1:0]       thr_wdata;
  logic [2*NCH-1:0]    word;
  logic                word_valid;

  trig_word_gen #(.NUM_CH(NCH), .SAMPLE_W(SW), .WINDOW_CYCLES(WIN),
                  .LOWER_RST(LO_RST), .UPPER_RST(HI_RST)) dut (
    .clk(clk), .rst_n(rst_n), .adc_data_i(adc_data), .adc_valid_i(adc_valid),
    .hit_i(hit), .thr_we_i(thr_we), .thr_sel_i(thr_sel), .thr_wdata_i(thr_wdata),
    .word_o(word), .word_valid_o(word_valid)
  );

  // staged stimulus
  logic          st_rst_n;
  int            st_smp [NCH];
  logic          st_sv;
  logic [NCH-1:0] st_hit;
  logic          st_we, st_sel;
  int            st_wdata;

  // behavioural model
  int             hist [NCH][$];
  logic [NCH-1:0] m_hit;
  int             m_lo, m_hi, m_cnt;
  logic           exp_valid;
  logic [2*NCH-1:0] exp_word;

  int n_checks = 0, n_errors = 0;
  int cyc = 0, last_pulse = -1;
  logic [2*NCH-1:0] cap_word;
  bit done = 0;

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) hist[c] = '{0, 0, 0};
    m_hit = '0; m_lo = LO_RST; m_hi = HI_RST; m_cnt = 0;
    exp_valid = 1'b0; exp_word = '0;
  endtask

  task automatic model_step();
    bit last;
    if (!st_rst_n) begin model_reset(); return; end
    last = (m_cnt == WIN - 1);
    for (int c = 0; c < NCH; c++) begin
      if (st_sv) begin hist[c].push_front(st_smp[c]); void'(hist[c].pop_back()); end
      if (st_hit[c]) m_hit[c] = 1'b1;
    end
    if (last) begin
      for (int c = 0; c < NCH; c++) begin
        int s, code;
        s = hist[c][0] + hist[c][1] + hist[c][2];
        if (!m_hit[c]) code = 0;
        else if (s >= m_hi) code = 3;
        else if (s >= m_lo) code = 2;
        else code = 1;
        exp_word[2*c +: 2] = 2'(code);
      end
      m_hit = '0;
    end
    exp_valid = last;
    if (st_we) begin
      if (st_sel) m_hi = st_wdata; else m_lo = st_wdata;
    end
    m_cnt = last ? 0 : m_cnt + 1;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    n_checks += 2;
    if (word_valid !== exp_valid) begin
      n_errors++;
      $display("FAIL R2 valid at cycle %0d: actual %b expected %b", cyc, word_valid, exp_valid);
    end
    if (word !== exp_word) begin
      n_errors++;
      $display("FAIL R3/R5/R6/R7 word at cycle %0d: actual %h expected %h", cyc, word, exp_word);
    end
    if (word_valid === 1'b1) begin
      cap_word = word;
      if (last_pulse >= 0) begin
        n_checks++;
        if (cyc - last_pulse != WIN) begin
          n_errors++;
          $display("FAIL R2 pulse spacing: actual %0d expected %0d", cyc - last_pulse, WIN);
        end
      end
      last_pulse = cyc;
    end
    rst_n = st_rst_n;
    for (int c = 0; c < NCH; c++) adc_data[c*SW +: SW] = SW'(st_smp[c]);
    adc_valid = st_sv; hit = st_hit;
    thr_we = st_we; thr_sel = st_sel; thr_wdata = (SW+2)'(st_wdata);
    model_step();
  endtask

  task automatic idle();
    st_sv = 1'b0; st_hit = '0; st_we = 1'b0;
  endtask

  task automatic align();
    idle();
    while (m_cnt != 0) step();
  endtask

  task automatic write_thr(input bit upper, input int val);
    idle(); st_we = 1'b1; st_sel = upper; st_wdata = val;
    step(); idle();
  endtask

  task automatic chk_code(input int ch, input int expv, input string tag);
    n_checks++;
    if (cap_word[2*ch +: 2] != 2'(expv)) begin
      n_errors++;
      $display("FAIL %s channel %0d code: actual %0d expected %0d", tag, ch, cap_word[2*ch +: 2], expv);
    end
  endtask

  task automatic set_all(input int v);
    for (int c = 0; c < NCH; c++) st_smp[c] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; adc_data = '0; adc_valid = 1'b0; hit = '0;
    thr_we = 1'b0; thr_sel = 1'b0; thr_wdata = '0;
    st_rst_n = 1'b0; set_all(0); idle(); st_sel = 1'b0; st_wdata = 0;
    model_reset();
    repeat (3) step();
    // R1: reset values checked by the scoreboard in the steps above
    n_checks++;
    if (word !== '0 || word_valid !== 1'b0) begin
      n_errors++;
      $display("FAIL R1 reset outputs: actual %h/%b expected 0/0", word, word_valid);
    end
    st_rst_n = 1'b1;
    step();

    // Phase 0 (R1): reset thresholds 64/512 decide the first codes
    align();
    for (int k = 0; k < WIN; k++) begin
      idle(); set_all(0); st_sv = 1'b1;
      st_smp[0] = 30; st_smp[1] = 200; st_smp[2] = 10;
      if (k == 10) st_hit[2:0] = 3'b111;
      step();
    end
    idle(); step();
    chk_code(0, 2, "R1"); chk_code(1, 3, "R1"); chk_code(2, 1, "R1");

    // Phase 1 (R5 R9 R4 R6): thresholds 100/1000
    write_thr(1'b0, 100); write_thr(1'b1, 1000);
    align();
    for (int k = 0; k < WIN; k++) begin
      idle(); set_all(0); st_sv = 1'b1;
      st_smp[0] = 20; st_smp[1] = 300; st_smp[2] = 4095; st_smp[3] = 4095;
      if (k == WIN - 1) st_hit[0] = 1'b1;
      if (k == 0) st_hit[1] = 1'b1;
      if (k == 9) st_hit[2] = 1'b1;
      if (k == 5) st_hit[47] = 1'b1;
      step();
    end
    idle(); step();
    chk_code(0, 1, "R4");  chk_code(1, 2, "R5"); chk_code(2, 3, "R9");
    chk_code(3, 0, "R5");  chk_code(47, 1, "R6");
    n_checks++;
    if (cap_word[95:94] != 2'd1 || cap_word[7:0] != 8'b00_11_10_01) begin
      n_errors++;
      $display("FAIL R6 packing: actual %h expected low byte 39 top 1", cap_word);
    end

    // Phase 2 (R3 R5): exact boundaries, invalid samples ignored
    align();
    for (int k = 0; k < WIN; k++) begin
      idle(); set_all(4095);
      if (k < 3) begin
        set_all(0); st_sv = 1'b1;
        st_smp[0] = 40; st_smp[1] = (k == 2) ? 334 : 333;
        st_smp[2] = (k == 2) ? 34 : 33; st_smp[3] = 33;
      end
      if (k == 7) st_hit[3:0] = 4'hF;
      step();
    end
    idle(); step();
    chk_code(0, 2, "R3"); chk_code(1, 3, "R5"); chk_code(2, 2, "R5"); chk_code(3, 1, "R5");

    // Phase 3 (R4): no hits, history persists, all codes zero
    align();
    for (int k = 0; k < WIN; k++) begin idle(); step(); end
    idle(); step();
    n_checks++;
    if (cap_word !== '0) begin
      n_errors++;
      $display("FAIL R4 stale hit: actual %h expected 0", cap_word);
    end

    // Phase 4 (R8): write in a window's last cycle applies only later
    align();
    for (int k = 0; k < WIN; k++) begin
      idle();
      if (k == 0) st_hit[0] = 1'b1;
      if (k == WIN - 1) begin st_we = 1'b1; st_sel = 1'b0; st_wdata = 5000; end
      step();
    end
    idle(); step();
    chk_code(0, 2, "R8");
    align();
    for (int k = 0; k < WIN; k++) begin
      idle(); if (k == 4) st_hit[1:0] = 2'b11;
      step();
    end
    idle(); step();
    chk_code(0, 1, "R8"); chk_code(1, 3, "R5");

    // Phase 5: random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      idle();
      st_sv = ($urandom % 3) != 0;
      for (int c = 0; c < NCH; c++) begin
        st_smp[c] = $urandom % 4096;
        st_hit[c] = ($urandom % 16) == 0;
      end
      if ($urandom % 50 == 0) begin
        st_we = 1'b1; st_sel = $urandom % 2; st_wdata = $urandom % 12288;
      end
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule